// File: doc/BRIEF.md
# Special-Register Access Permission Checker

This block sits in the decode stage. It looks at each instruction that moves data to or from a special register and decides what should happen to it. It takes the register number, whether the access is a read or a write, the current privilege state, and a control bit that selects whether undefined register numbers trap or are quietly skipped. From these it chooses one of four actions: execute normally, skip as a no-op, return a constant zero, or raise a hypervisor emulation assistance trap. It also drives the write enable for the general-purpose destination and the write enable for the special register. For registers served by the slow read path, it selects the slow-read multiplexer input.

The set of implemented registers is a constant table held in the package. Each entry carries the register number, a kind (fast, slow, read-as-zero, read-only zero), a flag that allows user-state access, and a 4-bit slow-read selector. The decision logic is purely combinational. Its results are captured in one register stage together with the instruction's valid bit. The register storage and the trap delivery are outside this block.

Top module: `spr_access_chk`

## Requirements
- R1: In privileged state, an access to register number 0, 4, 5 or 6 yields action TRAP (code 3), whatever the direction and the undefined-trap control.
- R2: In privileged state, an access to a number absent from the table yields TRAP (3) when the undefined-trap control is 1, and NOP (1) when it is 0.
- R3: A NOP result asserts neither the general-register write enable nor the special-register write enable, so the destination keeps its old value.
- R4: In user state, an access to a number absent from the table, or to an entry not marked user-accessible, yields TRAP (3), whatever the undefined-trap control.
- R5: A read of a read-as-zero register (740, 741 user-accessible; 760, 761 privileged) yields ZERO (2), with the general write enable at 1, the zero-source flag at 1 and the selector at 0. A write to one of them yields NOP with no trap.
- R6: The relocation-offset register 310 is privileged only. Reading it yields ZERO, and writing it yields NOP.
- R7: Slow registers drive out_slow=1 with their selector: 3 gives 1, 22 gives 2, 268 gives 3, and both log registers 880 and 881 give the shared code 7.
- R8: An allowed access to a fast or slow register yields EXEC (0). A read sets only the general write enable, and a write sets only the special write enable. Fast registers are 1, 8, 9 (user) and 16 to 19 (privileged).
- R9: Every result appears one clock after its in_valid cycle, with out_valid=1. A cycle without in_valid gives out_valid=0 and both write enables at 0 one clock later.
- R10: While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_sprn | input | 10 | Special-register number |
| in_is_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| in_priv | input | 1 | 1 = privileged/hypervisor state, 0 = user state |
| in_trap_undef | input | 1 | 1 = undefined numbers trap in privileged state |
| out_valid | output | 1 | Registered result valid |
| out_action | output | 2 | 0 EXEC, 1 NOP, 2 ZERO, 3 TRAP |
| out_gpr_we | output | 1 | Destination general register write enable |
| out_spr_we | output | 1 | Special register write enable |
| out_slow | output | 1 | Read served by the slow-read multiplexer |
| out_rd_sel | output | 4 | Slow-read multiplexer selector |
| out_zero_src | output | 1 | Select the constant-zero read source |

## Verification
The bench builds the block with its default widths: a 10-bit register number and a 4-bit selector. At that size, every register number from 0 to 1023 can be swept under both privilege states, both values of the undefined-trap control and both directions. That gives 8192 combinations, and each full output tuple is compared against a reference table written separately in the bench. The sweep covers the fixed trap numbers, the shared log selector, the read-as-zero group, the relocation register and every undefined number. Idle cycles between bursts check that the enables drop.

// File: rtl/spr_pkg.sv
package spr_pkg;

  localparam int SPRN_W = 10;
  localparam int SEL_W  = 4;
  localparam int N_ENT  = 17;
  localparam int N_FIXED = 4;

  typedef enum logic [1:0] {
    ACT_EXEC = 2'd0,
    ACT_NOP  = 2'd1,
    ACT_ZERO = 2'd2,
    ACT_TRAP = 2'd3
  } act_e;

  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_FAST = 3'd1,
    K_SLOW = 3'd2,
    K_RAZ  = 3'd3,
    K_ROZ  = 3'd4
  } kind_e;

  typedef struct packed {
    logic [SPRN_W-1:0] num;
    kind_e             kind;
    logic              user_ok;
    logic [SEL_W-1:0]  sel;
  } ent_t;

  localparam logic [SEL_W-1:0] SEL_ZERO = '0;
  localparam logic [SEL_W-1:0] SEL_LOG  = SEL_W'(7);

  function automatic ent_t entry_at(input int idx);
    ent_t e;
    case (idx)
      0:  e = '{num: SPRN_W'(1),   kind: K_FAST, user_ok: 1'b1, sel: '0};
      1:  e = '{num: SPRN_W'(8),   kind: K_FAST, user_ok: 1'b1, sel: '0};
      2:  e = '{num: SPRN_W'(9),   kind: K_FAST, user_ok: 1'b1, sel: '0};
      3:  e = '{num: SPRN_W'(16),  kind: K_FAST, user_ok: 1'b0, sel: '0};
      4:  e = '{num: SPRN_W'(17),  kind: K_FAST, user_ok: 1'b0, sel: '0};
      5:  e = '{num: SPRN_W'(18),  kind: K_FAST, user_ok: 1'b0, sel: '0};
      6:  e = '{num: SPRN_W'(19),  kind: K_FAST, user_ok: 1'b0, sel: '0};
      7:  e = '{num: SPRN_W'(3),   kind: K_SLOW, user_ok: 1'b1, sel: SEL_W'(1)};
      8:  e = '{num: SPRN_W'(22),  kind: K_SLOW, user_ok: 1'b0, sel: SEL_W'(2)};
      9:  e = '{num: SPRN_W'(268), kind: K_SLOW, user_ok: 1'b1, sel: SEL_W'(3)};
      10: e = '{num: SPRN_W'(880), kind: K_SLOW, user_ok: 1'b0, sel: SEL_LOG};
      11: e = '{num: SPRN_W'(881), kind: K_SLOW, user_ok: 1'b0, sel: SEL_LOG};
      12: e = '{num: SPRN_W'(740), kind: K_RAZ,  user_ok: 1'b1, sel: SEL_ZERO};
      13: e = '{num: SPRN_W'(741), kind: K_RAZ,  user_ok: 1'b1, sel: SEL_ZERO};
      14: e = '{num: SPRN_W'(760), kind: K_RAZ,  user_ok: 1'b0, sel: SEL_ZERO};
      15: e = '{num: SPRN_W'(761), kind: K_RAZ,  user_ok: 1'b0, sel: SEL_ZERO};
      default: e = '{num: SPRN_W'(310), kind: K_ROZ, user_ok: 1'b0, sel: SEL_ZERO};
    endcase
    return e;
  endfunction

  function automatic logic [SPRN_W-1:0] fixed_at(input int idx);
    case (idx)
      0:       return SPRN_W'(0);
      1:       return SPRN_W'(4);
      2:       return SPRN_W'(5);
      default: return SPRN_W'(6);
    endcase
  endfunction

endpackage

// File: rtl/spr_lookup.sv
module spr_lookup
  import spr_pkg::*;
#(
  parameter int NUM_ENT = N_ENT
) (
  input  logic [SPRN_W-1:0] sprn,
  output logic              found,
  output kind_e             kind,
  output logic              user_ok,
  output logic [SEL_W-1:0]  sel
);

  logic [NUM_ENT-1:0] hit;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    localparam ent_t ENT = entry_at(g);
    assign hit[g] = (sprn == ENT.num);
  end

  always_comb begin
    found   = |hit;
    kind    = K_NONE;
    user_ok = 1'b0;
    sel     = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (hit[i]) begin
        kind    = entry_at(i).kind;
        user_ok = entry_at(i).user_ok;
        sel     = entry_at(i).sel;
      end
    end
  end

endmodule

// File: rtl/spr_rules.sv
module spr_rules
  import spr_pkg::*;
(
  input  logic [SPRN_W-1:0] sprn,
  input  logic              is_write,
  input  logic              priv,
  input  logic              trap_undef,
  input  logic              found,
  input  kind_e             kind,
  input  logic              user_ok,
  input  logic [SEL_W-1:0]  sel,
  output act_e              action,
  output logic              gpr_we,
  output logic              spr_we,
  output logic              slow,
  output logic [SEL_W-1:0]  rd_sel,
  output logic              zero_src
);

  logic [N_FIXED-1:0] fixed_hit;

  for (genvar g = 0; g < N_FIXED; g++) begin : g_fix
    assign fixed_hit[g] = (sprn == fixed_at(g));
  end

  always_comb begin
    if (priv && (|fixed_hit)) begin
      action = ACT_TRAP;
    end else if (!found) begin
      action = (priv && !trap_undef) ? ACT_NOP : ACT_TRAP;
    end else if (!priv && !user_ok) begin
      action = ACT_TRAP;
    end else if (kind == K_RAZ || kind == K_ROZ) begin
      action = is_write ? ACT_NOP : ACT_ZERO;
    end else begin
      action = ACT_EXEC;
    end
  end

  always_comb begin
    gpr_we   = 1'b0;
    spr_we   = 1'b0;
    slow     = 1'b0;
    rd_sel   = '0;
    zero_src = 1'b0;
    case (action)
      ACT_EXEC: begin
        gpr_we = !is_write;
        spr_we = is_write;
        if (kind == K_SLOW) begin
          slow   = 1'b1;
          rd_sel = sel;
        end
      end
      ACT_ZERO: begin
        gpr_we   = 1'b1;
        zero_src = 1'b1;
        rd_sel   = SEL_ZERO;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/spr_outreg.sv
module spr_outreg
  import spr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             d_valid,
  input  act_e             d_action,
  input  logic             d_gpr_we,
  input  logic             d_spr_we,
  input  logic             d_slow,
  input  logic [SEL_W-1:0] d_rd_sel,
  input  logic             d_zero_src,
  output logic             q_valid,
  output act_e             q_action,
  output logic             q_gpr_we,
  output logic             q_spr_we,
  output logic             q_slow,
  output logic [SEL_W-1:0] q_rd_sel,
  output logic             q_zero_src
);

  logic             ld_en;
  logic             n_valid, n_gpr_we, n_spr_we, n_slow, n_zero_src;
  act_e             n_action;
  logic [SEL_W-1:0] n_rd_sel;

  assign ld_en = d_valid | q_valid;

  always_comb begin
    n_valid    = d_valid;
    n_action   = d_valid ? d_action : ACT_EXEC;
    n_gpr_we   = d_valid & d_gpr_we;
    n_spr_we   = d_valid & d_spr_we;
    n_slow     = d_valid & d_slow;
    n_rd_sel   = d_valid ? d_rd_sel : '0;
    n_zero_src = d_valid & d_zero_src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid    <= 1'b0;
      q_action   <= ACT_EXEC;
      q_gpr_we   <= 1'b0;
      q_spr_we   <= 1'b0;
      q_slow     <= 1'b0;
      q_rd_sel   <= '0;
      q_zero_src <= 1'b0;
    end else if (ld_en) begin
      q_valid    <= n_valid;
      q_action   <= n_action;
      q_gpr_we   <= n_gpr_we;
      q_spr_we   <= n_spr_we;
      q_slow     <= n_slow;
      q_rd_sel   <= n_rd_sel;
      q_zero_src <= n_zero_src;
    end
  end

endmodule

// File: rtl/spr_access_chk.sv
module spr_access_chk
  import spr_pkg::*;
#(
  parameter int NUM_ENT = N_ENT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [SPRN_W-1:0] in_sprn,
  input  logic              in_is_write,
  input  logic              in_priv,
  input  logic              in_trap_undef,
  output logic              out_valid,
  output logic [1:0]        out_action,
  output logic              out_gpr_we,
  output logic              out_spr_we,
  output logic              out_slow,
  output logic [SEL_W-1:0]  out_rd_sel,
  output logic              out_zero_src
);

  logic             lk_found, lk_user_ok;
  kind_e            lk_kind;
  logic [SEL_W-1:0] lk_sel;
  act_e             rl_action, q_action;
  logic             rl_gpr_we, rl_spr_we, rl_slow, rl_zero_src;
  logic [SEL_W-1:0] rl_rd_sel;

  spr_lookup #(.NUM_ENT(NUM_ENT)) u_lookup (
    .sprn    (in_sprn),
    .found   (lk_found),
    .kind    (lk_kind),
    .user_ok (lk_user_ok),
    .sel     (lk_sel)
  );

  spr_rules u_rules (
    .sprn       (in_sprn),
    .is_write   (in_is_write),
    .priv       (in_priv),
    .trap_undef (in_trap_undef),
    .found      (lk_found),
    .kind       (lk_kind),
    .user_ok    (lk_user_ok),
    .sel        (lk_sel),
    .action     (rl_action),
    .gpr_we     (rl_gpr_we),
    .spr_we     (rl_spr_we),
    .slow       (rl_slow),
    .rd_sel     (rl_rd_sel),
    .zero_src   (rl_zero_src)
  );

  spr_outreg u_outreg (
    .clk        (clk),
    .rst_n      (rst_n),
    .d_valid    (in_valid),
    .d_action   (rl_action),
    .d_gpr_we   (rl_gpr_we),
    .d_spr_we   (rl_spr_we),
    .d_slow     (rl_slow),
    .d_rd_sel   (rl_rd_sel),
    .d_zero_src (rl_zero_src),
    .q_valid    (out_valid),
    .q_action   (q_action),
    .q_gpr_we   (out_gpr_we),
    .q_spr_we   (out_spr_we),
    .q_slow     (out_slow),
    .q_rd_sel   (out_rd_sel),
    .q_zero_src (out_zero_src)
  );

  assign out_action = q_action;

endmodule

// File: rtl/spr_access_chk_checker.sv
module spr_access_chk_checker
  import spr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [SPRN_W-1:0] in_sprn,
  input logic              in_is_write,
  input logic              in_priv,
  input logic              in_trap_undef,
  input logic              out_valid,
  input logic [1:0]        out_action,
  input logic              out_gpr_we,
  input logic              out_spr_we,
  input logic              out_slow,
  input logic [SEL_W-1:0]  out_rd_sel,
  input logic              out_zero_src
);

  logic fixed_num;
  assign fixed_num = (in_sprn == SPRN_W'(0)) || (in_sprn == SPRN_W'(4)) ||
                     (in_sprn == SPRN_W'(5)) || (in_sprn == SPRN_W'(6));

  AST_FIXED_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_priv && fixed_num |=> out_action == 2'd3); // R1

  AST_NOP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_action == 2'd1 |-> !out_gpr_we && !out_spr_we); // R3

  AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_action == 2'd3 |-> !out_gpr_we && !out_spr_we); // R4

  AST_ZERO_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    out_zero_src |-> out_gpr_we && out_rd_sel == '0 && !out_slow); // R5

  AST_WRITE_NO_GPR: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_is_write |=> !out_gpr_we && !out_zero_src); // R8

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_gpr_we && !out_spr_we && !out_zero_src); // R9

  AST_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_gpr_we && out_spr_we)); // R8

endmodule

bind spr_access_chk spr_access_chk_checker u_chk (.*);

// File: tb/spr_access_chk_tb.sv
module spr_access_chk_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [9:0] in_sprn;
  logic       in_is_write, in_priv, in_trap_undef;
  logic       out_valid, out_gpr_we, out_spr_we, out_slow, out_zero_src;
  logic [1:0] out_action;
  logic [3:0] out_rd_sel;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spr_access_chk u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sprn(in_sprn),
    .in_is_write(in_is_write), .in_priv(in_priv), .in_trap_undef(in_trap_undef),
    .out_valid(out_valid), .out_action(out_action), .out_gpr_we(out_gpr_we),
    .out_spr_we(out_spr_we), .out_slow(out_slow), .out_rd_sel(out_rd_sel),
    .out_zero_src(out_zero_src)
  );

  // reference kinds: 0 none, 1 fast, 2 slow, 3 zero-group, 4 relocation
  task automatic ref_class(input int n, output int kind, output bit uok, output int sel);
    kind = 0; uok = 0; sel = 0;
    if (n == 1 || n == 8 || n == 9) begin kind = 1; uok = 1; end
    else if (n >= 16 && n <= 19) kind = 1;
    else if (n == 3)   begin kind = 2; uok = 1; sel = 1; end
    else if (n == 22)  begin kind = 2; sel = 2; end
    else if (n == 268) begin kind = 2; uok = 1; sel = 3; end
    else if (n == 880 || n == 881) begin kind = 2; sel = 7; end
    else if (n == 740 || n == 741) begin kind = 3; uok = 1; end
    else if (n == 760 || n == 761) kind = 3;
    else if (n == 310) kind = 4;
  endtask

  // packs {valid, action[1:0], gpr_we, spr_we, slow, sel[3:0], zero}
  task automatic expect_out(input int n, input bit wr, input bit pv, input bit ev,
                            output logic [10:0] exp, output string tag);
    int kind, sel, act;
    bit uok, g, s, sl, z;
    ref_class(n, kind, uok, sel);
    g = 0; s = 0; sl = 0; z = 0;
    if (pv && (n == 0 || n == 4 || n == 5 || n == 6)) begin act = 3; tag = "R1"; end
    else if (kind == 0) begin
      if (pv) begin act = ev ? 3 : 1; tag = "R2"; end
      else begin act = 3; tag = "R4"; end
    end
    else if (!pv && !uok) begin act = 3; tag = "R4"; end
    else if (kind >= 3) begin
      act = wr ? 1 : 2; tag = (kind == 4) ? "R6" : "R5";
      if (!wr) begin g = 1; z = 1; end
    end
    else begin
      act = 0; tag = (kind == 2) ? "R7" : "R8";
      g = !wr; s = wr;
      if (kind == 2) sl = 1; else sel = 0;
    end
    if (act == 1) tag = {tag, "/R3"};
    if (act != 0) sel = 0;
    if (act == 0 && kind != 2) sel = 0;
    exp = {1'b1, act[1:0], g, s, sl, sel[3:0], z};
  endtask

  function automatic logic [10:0] got_out();
    return {out_valid, out_action, out_gpr_we, out_spr_we, out_slow, out_rd_sel, out_zero_src};
  endfunction

  task automatic check(input logic [10:0] got, input logic [10:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b (valid,act,gwe,swe,slow,sel,zero)", tag, got, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [10:0] exp;
    string tag;
    rst_n = 1'b0; in_valid = 0; in_sprn = '0; in_is_write = 0; in_priv = 0; in_trap_undef = 0;
    repeat (3) @(negedge clk);
    check(got_out(), 11'b0, "R10 reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(got_out(), 11'b0, "R9 idle after reset");

    for (int pv = 0; pv < 2; pv++) begin
      for (int ev = 0; ev < 2; ev++) begin
        for (int wr = 0; wr < 2; wr++) begin
          for (int n = 0; n < 1024; n++) begin
            in_valid = 1; in_sprn = 10'(n); in_is_write = wr[0];
            in_priv = pv[0]; in_trap_undef = ev[0];
            @(negedge clk);
            expect_out(n, wr[0], pv[0], ev[0], exp, tag);
            check(got_out(), exp, tag);
          end
          in_valid = 0;
          @(negedge clk);
          check({out_valid, out_gpr_we, out_spr_we, out_zero_src}, 11'b0, "R9 idle gap");
        end
      end
    end

    // reset mid-stream clears outputs
    in_valid = 1; in_sprn = 10'd1; in_is_write = 0; in_priv = 1; in_trap_undef = 0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(got_out(), 11'b0, "R10 async reset");
    in_valid = 0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule